// File: doc/BRIEF.md
# Register-Addressed I2C Transfer Sequencer

This block runs whole I2C transfers on top of a byte-level bus engine. A host hands it one request at a time: an operation (probe, write or read), a 7-bit target address, a sub-address of up to `SUB_BYTES` bytes with its length, and a byte count. The sequencer turns the request into a series of engine commands: start condition, stop condition, byte write and byte read. It waits for each command's completion and acknowledge result before it issues the next one. Bit timing and pad drive belong to the engine and are not handled here.

Write payload comes in over a valid/ready stream, one byte per handshake. Read payload goes out as one byte per `rd_valid` strobe. When a transfer ends, the block pulses `done` and holds `err` and the count of data bytes the target refused. Requests are taken only while the sequencer is idle.

Two options are set per request:
- The read turnaround after the sub-address phase is either a repeated start or a stop followed by a start.
- For memories that take high address bits in the device address, the sub-address bits above the transmitted bytes can be masked and merged into the 7-bit target address.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After synchronous reset the block is idle. `req_ready` is 1, and `done`, `eng_cmd_valid`, `wr_ready` and `rd_valid` are 0.
- R2: A probe (`req_op`=0) issues start, a byte write of {address, 0}, then stop. `err` reports whether that byte was refused. Engine command codes are 0 start, 1 stop, 2 byte write, 3 byte read.
- R3: Sub-address bytes are sent most significant first. Exactly `req_alen` of them are sent, from 0 up to `SUB_BYTES`.
- R4: A write (`req_op`=1) issues start, {address, 0}, the sub-address bytes, then each payload byte in the order it was taken from the write stream, then stop. `wr_ready` stays high until a byte is taken.
- R5: During a write, a refused payload byte does not end the transfer. `fail_cnt` reports how many payload bytes were refused, and `err` stays 0.
- R6: A refused {address, 0} byte in a write or addressed read causes a stop, then `done` with `err`=1. A refused sub-address byte ends the transfer at once with `err`=1 and no stop.
- R7: A read (`req_op`=2) with a nonzero sub-address length follows the sub-address bytes with a start only when `cfg_rep_start`=1. When it is 0, a stop and then a start follow instead. Either way, {address, 1} comes next.
- R8: A read with a zero sub-address length skips the addressing phase: {address, 1} follows the first start directly.
- R9: Each read byte command sets `eng_rd_nack`=0 except the last, which sets it to 1. A stop follows, and every byte received appears on `rd_data` with a one-cycle `rd_valid`.
- R10: When `cfg_fold_en`=1 on a read or write, the address sent is `req_chip | ((req_sub >> 8*req_alen) & cfg_fold_mask)`.
- R11: Only one engine command is outstanding. `eng_cmd_valid` is a one-cycle pulse, and the next one comes only after `eng_done`.
- R12: A request is accepted only while `req_ready` is 1, and `req_ready` falls after acceptance. A `req_valid` raised during a transfer is ignored.
- R13: `done` is a one-cycle pulse. `err` and `fail_cnt` keep their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Idle, request can be taken |
| req_op | input | 2 | 0 probe, 1 write, 2 read |
| req_chip | input | 7 | Target address |
| req_sub | input | 8*SUB_BYTES | Sub-address value |
| req_alen | input | clog2(SUB_BYTES+1) | Sub-address length in bytes |
| req_len | input | LEN_W | Payload byte count |
| cfg_rep_start | input | 1 | Read turnaround by repeated start |
| cfg_fold_en | input | 1 | Merge high sub-address bits into target address |
| cfg_fold_mask | input | 7 | Mask for merged bits |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken when both high |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Transfer finished pulse |
| err | output | 1 | Transfer failed |
| fail_cnt | output | CNT_W | Refused payload bytes of last write |
| eng_cmd_valid | output | 1 | Engine command pulse |
| eng_cmd | output | 2 | Engine command code |
| eng_wdata | output | 8 | Byte for a write command |
| eng_rd_nack | output | 1 | Refuse the byte of a read command |
| eng_done | input | 1 | Engine finished the command |
| eng_nack | input | 1 | Written byte was refused |
| eng_rdata | input | 8 | Byte received by a read command |

## Verification
The bench models the engine and the target from a per-transfer script of expected commands and their replies. The script is built from the request fields alone. Probes with an acknowledge and with a refusal separate the two status outcomes. Writes with sub-address lengths 0, 2 and 4 and payload refusal masks separate byte order and length from abort behaviour. Reads are run with both turnaround settings and with zero and nonzero sub-address length, which pins down which start/stop pattern each case produces. Further runs cover fold-enabled address merging, aborts at the address and at a middle sub-address byte, single-byte reads and a request raised while busy.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_STOP  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_READ  = 2'd3
  } cmd_e;

  typedef enum logic [3:0] {
    STP_START1,
    STP_CHIPW,
    STP_SUB,
    STP_MIDSTOP,
    STP_START2,
    STP_CHIPR,
    STP_RDATA,
    STP_WDATA,
    STP_STOP
  } step_e;
endpackage

// File: rtl/i2c_seq_fold.sv
// Target address merge for memories that take high address bits in the device address.
module i2c_seq_fold #(
  parameter int SUB_BYTES = 4,
  localparam int SUB_W  = SUB_BYTES * 8,
  localparam int ALEN_W = $clog2(SUB_BYTES + 1)
) (
  input  logic [6:0]        chip,
  input  logic [SUB_W-1:0]  sub,
  input  logic [ALEN_W-1:0] alen,
  input  logic              fold_en,
  input  logic [6:0]        fold_mask,
  output logic [6:0]        eff_chip
);
  logic [SUB_W-1:0] above;

  // Bits above the transmitted sub-address bytes.
  assign above    = sub >> {alen, 3'b000};
  assign eff_chip = fold_en ? (chip | (above[6:0] & fold_mask)) : chip;
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter int SUB_BYTES = 4,
  parameter int LEN_W     = 8,
  parameter int CNT_W     = 8,
  localparam int SUB_W  = SUB_BYTES * 8,
  localparam int ALEN_W = $clog2(SUB_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [6:0]        req_chip_eff,
  input  logic [SUB_W-1:0]  req_sub,
  input  logic [ALEN_W-1:0] req_alen,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_rep,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              err,
  output logic [CNT_W-1:0]  fail_cnt,
  output logic              eng_cmd_valid,
  output logic [1:0]        eng_cmd,
  output logic [7:0]        eng_wdata,
  output logic              eng_rd_nack,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [7:0]        eng_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_CMD, S_WAIT} st_e;

  st_e               st;
  step_e             step;
  op_e               op_q;
  logic              rep_q;
  logic [6:0]        chip_q;
  logic [SUB_W-1:0]  sub_q;
  logic [ALEN_W-1:0] alen_q;
  logic [ALEN_W-1:0] sub_left;
  logic [LEN_W-1:0]  left;

  cmd_e              nxt_cmd;
  logic [7:0]        nxt_byte;
  logic              nxt_nack;
  logic [7:0]        sub_byte;
  logic [ALEN_W-1:0] sel;
  step_e             data_step;

  assign req_ready = (st == S_IDLE);
  assign data_step = (left != '0) ? STP_WDATA : STP_STOP;
  assign sel       = sub_left - ALEN_W'(1);

  // Most significant remaining sub-address byte.
  always_comb begin
    sub_byte = '0;
    for (int g = 0; g < SUB_BYTES; g++) begin
      if (sel == ALEN_W'(g)) sub_byte = sub_q[8*g +: 8];
    end
  end

  always_comb begin
    nxt_cmd  = CMD_START;
    nxt_byte = '0;
    nxt_nack = 1'b0;
    case (step)
      STP_START1, STP_START2: nxt_cmd = CMD_START;
      STP_MIDSTOP, STP_STOP:  nxt_cmd = CMD_STOP;
      STP_CHIPW: begin nxt_cmd = CMD_WRITE; nxt_byte = {chip_q, 1'b0}; end
      STP_CHIPR: begin nxt_cmd = CMD_WRITE; nxt_byte = {chip_q, 1'b1}; end
      STP_SUB:   begin nxt_cmd = CMD_WRITE; nxt_byte = sub_byte; end
      STP_RDATA: begin nxt_cmd = CMD_READ;  nxt_nack = (left == LEN_W'(1)); end
      default:   nxt_cmd = CMD_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      step          <= STP_START1;
      op_q          <= OP_PROBE;
      rep_q         <= 1'b0;
      chip_q        <= '0;
      sub_q         <= '0;
      alen_q        <= '0;
      sub_left      <= '0;
      left          <= '0;
      wr_ready      <= 1'b0;
      rd_valid      <= 1'b0;
      rd_data       <= '0;
      done          <= 1'b0;
      err           <= 1'b0;
      fail_cnt      <= '0;
      eng_cmd_valid <= 1'b0;
      eng_cmd       <= CMD_START;
      eng_wdata     <= '0;
      eng_rd_nack   <= 1'b0;
    end else begin
      eng_cmd_valid <= 1'b0;
      done          <= 1'b0;
      rd_valid      <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q     <= op_e'(req_op);
          rep_q    <= req_rep;
          chip_q   <= req_chip_eff;
          sub_q    <= req_sub;
          alen_q   <= req_alen;
          sub_left <= req_alen;
          left     <= req_len;
          err      <= 1'b0;
          fail_cnt <= '0;
          step     <= STP_START1;
          st       <= S_CMD;
        end
        S_CMD: begin
          if (step == STP_WDATA) begin
            if (wr_ready && wr_valid) begin
              wr_ready      <= 1'b0;
              eng_cmd_valid <= 1'b1;
              eng_cmd       <= CMD_WRITE;
              eng_wdata     <= wr_data;
              eng_rd_nack   <= 1'b0;
              st            <= S_WAIT;
            end else begin
              wr_ready <= 1'b1;
            end
          end else begin
            eng_cmd_valid <= 1'b1;
            eng_cmd       <= nxt_cmd;
            eng_wdata     <= nxt_byte;
            eng_rd_nack   <= nxt_nack;
            st            <= S_WAIT;
          end
        end
        S_WAIT: if (eng_done) begin
          st <= S_CMD;
          case (step)
            STP_START1:
              step <= (op_q == OP_READ && alen_q == '0) ? STP_CHIPR : STP_CHIPW;
            STP_CHIPW: begin
              if (eng_nack) begin
                err  <= 1'b1;
                step <= STP_STOP;
              end else if (op_q == OP_PROBE) step <= STP_STOP;
              else if (alen_q != '0)         step <= STP_SUB;
              else                           step <= data_step;
            end
            STP_SUB: begin
              if (eng_nack) begin
                err  <= 1'b1;
                done <= 1'b1;
                st   <= S_IDLE;
              end else begin
                sub_left <= sub_left - ALEN_W'(1);
                if (sub_left == ALEN_W'(1)) begin
                  if (op_q == OP_READ) step <= rep_q ? STP_START2 : STP_MIDSTOP;
                  else                 step <= data_step;
                end
              end
            end
            STP_MIDSTOP: step <= STP_START2;
            STP_START2:  step <= STP_CHIPR;
            STP_CHIPR:   step <= (left != '0) ? STP_RDATA : STP_STOP;
            STP_RDATA: begin
              rd_valid <= 1'b1;
              rd_data  <= eng_rdata;
              left     <= left - LEN_W'(1);
              if (left == LEN_W'(1)) step <= STP_STOP;
            end
            STP_WDATA: begin
              if (eng_nack && fail_cnt != '1) fail_cnt <= fail_cnt + CNT_W'(1);
              left <= left - LEN_W'(1);
              if (left == LEN_W'(1)) step <= STP_STOP;
            end
            STP_STOP: begin
              done <= 1'b1;
              st   <= S_IDLE;
            end
            default: st <= S_IDLE;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Assertion helpers: outstanding command and last read refusal.
  logic pend;
  logic last_rd_nack;
  always_ff @(posedge clk) begin
    if (rst) begin
      pend         <= 1'b0;
      last_rd_nack <= 1'b0;
    end else begin
      if (eng_cmd_valid)  pend <= 1'b1;
      else if (eng_done)  pend <= 1'b0;
      if (eng_cmd_valid) last_rd_nack <= (eng_cmd == CMD_READ) && eng_rd_nack;
    end
  end

  assert_one_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    eng_cmd_valid |-> !pend);
  assert_cmd_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    eng_cmd_valid |=> !eng_cmd_valid);
  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && !wr_valid) |=> wr_ready);
  assert_last_read_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (eng_cmd_valid && last_rd_nack) |-> (eng_cmd == CMD_STOP));
  assert_fail_mono_R5: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> (fail_cnt >= $past(fail_cnt)));
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_accept_R12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_seq_pkg::*;
#(
  parameter int SUB_BYTES = 4,
  parameter int LEN_W     = 8,
  parameter int CNT_W     = 8,
  localparam int SUB_W  = SUB_BYTES * 8,
  localparam int ALEN_W = $clog2(SUB_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [6:0]        req_chip,
  input  logic [SUB_W-1:0]  req_sub,
  input  logic [ALEN_W-1:0] req_alen,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              cfg_rep_start,
  input  logic              cfg_fold_en,
  input  logic [6:0]        cfg_fold_mask,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              err,
  output logic [CNT_W-1:0]  fail_cnt,
  output logic              eng_cmd_valid,
  output logic [1:0]        eng_cmd,
  output logic [7:0]        eng_wdata,
  output logic              eng_rd_nack,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [7:0]        eng_rdata
);
  logic [6:0] chip_eff;
  logic       fold_on;

  assign fold_on = cfg_fold_en && (req_op != OP_PROBE);

  i2c_seq_fold #(.SUB_BYTES(SUB_BYTES)) u_fold (
    .chip      (req_chip),
    .sub       (req_sub),
    .alen      (req_alen),
    .fold_en   (fold_on),
    .fold_mask (cfg_fold_mask),
    .eff_chip  (chip_eff)
  );

  i2c_seq_fsm #(.SUB_BYTES(SUB_BYTES), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .req_chip_eff  (chip_eff),
    .req_sub       (req_sub),
    .req_alen      (req_alen),
    .req_len       (req_len),
    .req_rep       (cfg_rep_start),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_data       (wr_data),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .done          (done),
    .err           (err),
    .fail_cnt      (fail_cnt),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_cmd       (eng_cmd),
    .eng_wdata     (eng_wdata),
    .eng_rd_nack   (eng_rd_nack),
    .eng_done      (eng_done),
    .eng_nack      (eng_nack),
    .eng_rdata     (eng_rdata)
  );
endmodule

// File: tb/test_i2c_xfer_seq.sv
module test_i2c_xfer_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [6:0]  req_chip = '0;
  logic [31:0] req_sub = '0;
  logic [2:0]  req_alen = '0;
  logic [7:0]  req_len = '0;
  logic        cfg_rep_start = 1'b0;
  logic        cfg_fold_en = 1'b0;
  logic [6:0]  cfg_fold_mask = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        done;
  logic        err;
  logic [7:0]  fail_cnt;
  logic        eng_cmd_valid;
  logic [1:0]  eng_cmd;
  logic [7:0]  eng_wdata;
  logic        eng_rd_nack;
  logic        eng_done = 1'b0;
  logic        eng_nack = 1'b0;
  logic [7:0]  eng_rdata = '0;

  always #2 clk = ~clk;

  i2c_xfer_seq i_i2c_xfer_seq (.*);

  typedef struct {
    logic [1:0] cmd;
    logic [7:0] byt;
    logic       rnack;
    logic       rsp_nack;
    logic [7:0] rsp_data;
  } item_t;

  item_t      exp_q[$];
  logic [7:0] rd_q[$];
  logic [7:0] wr_q[$];
  int         checks = 0;
  int         errors = 0;
  int         ncmd = 0;
  string      cur_tag = "";
  bit         finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic void push_item(input logic [1:0] c, input logic [7:0] b,
                                    input logic rn, input logic rspn, input logic [7:0] rd);
    item_t it;
    it.cmd = c; it.byt = b; it.rnack = rn; it.rsp_nack = rspn; it.rsp_data = rd;
    exp_q.push_back(it);
  endfunction

  // Engine and target model driven by the expected script.
  always begin : engine
    item_t cur;
    bit    have;
    bit    overlap;
    @(negedge clk);
    if (eng_cmd_valid) begin
      ncmd++;
      have = (exp_q.size() != 0);
      chk(have, cur_tag, "command present in script", {62'd0, eng_cmd}, 64'hff);
      if (have) begin
        cur = exp_q.pop_front();
        chk(eng_cmd == cur.cmd, cur_tag, "command code", eng_cmd, cur.cmd);
        if (cur.cmd == 2'd2) chk(eng_wdata == cur.byt, cur_tag, "written byte", eng_wdata, cur.byt);
        if (cur.cmd == 2'd3) chk(eng_rd_nack == cur.rnack, "R9", "read refusal bit", eng_rd_nack, cur.rnack);
      end else begin
        cur.rsp_nack = 1'b0; cur.rsp_data = 8'h00;
      end
      overlap = 0;
      repeat (1 + (ncmd % 3)) begin
        @(negedge clk);
        if (eng_cmd_valid) overlap = 1;
      end
      chk(!overlap, "R11", "no command while one outstanding", overlap, 0);
      eng_nack  = cur.rsp_nack;
      eng_rdata = cur.rsp_data;
      eng_done  = 1'b1;
      @(negedge clk);
      eng_done  = 1'b0;
      eng_nack  = 1'b0;
    end
  end

  // Read data monitor.
  always @(negedge clk) begin
    if (rd_valid) begin
      if (rd_q.size() == 0) chk(0, "R9", "unexpected read byte", rd_data, 64'hfff);
      else begin
        logic [7:0] e;
        e = rd_q.pop_front();
        chk(rd_data == e, "R9", "read byte", rd_data, e);
      end
    end
  end

  // Write stream driver.
  bit take_pending = 0;
  always @(negedge clk) begin
    if (take_pending && wr_q.size() != 0) void'(wr_q.pop_front());
    wr_valid = (wr_q.size() != 0);
    wr_data  = wr_valid ? wr_q[0] : 8'h00;
    take_pending = wr_valid && wr_ready;
  end

  task automatic run_txn(input logic [1:0] op, input logic [6:0] chip, input logic [31:0] sub,
                         input int alen, input int len, input bit rep, input bit fold,
                         input logic [6:0] mask, input bit nchip, input int nsub,
                         input logic [31:0] wnack, input logic [7:0] base, input bit poke,
                         input string tag);
    logic [6:0]  eff;
    logic [63:0] wide;
    bit          xerr;
    int          xfail;
    bit          aborted;
    xerr = 0; xfail = 0; aborted = 0;
    cur_tag = tag;
    wide = {32'd0, sub} >> (8 * alen);
    eff = (fold && op != 2'd0) ? (chip | (wide[6:0] & mask)) : chip;
    push_item(2'd0, 8'h00, 0, 0, 8'h00);
    if (op == 2'd0) begin
      push_item(2'd2, {chip, 1'b0}, 0, nchip, 8'h00);
      push_item(2'd1, 8'h00, 0, 0, 8'h00);
      xerr = nchip;
    end else begin
      if (op == 2'd1 || alen > 0) begin
        push_item(2'd2, {eff, 1'b0}, 0, nchip, 8'h00);
        if (nchip) begin
          push_item(2'd1, 8'h00, 0, 0, 8'h00);
          xerr = 1; aborted = 1;
        end
        if (!aborted) begin
          for (int p = 0; p < alen; p++) begin
            push_item(2'd2, sub[8*(alen-1-p) +: 8], 0, (p == nsub), 8'h00);
            if (p == nsub) begin xerr = 1; aborted = 1; break; end
          end
        end
      end
      if (!aborted) begin
        if (op == 2'd1) begin
          for (int k = 0; k < len; k++) begin
            wr_q.push_back(base + 8'(k));
            push_item(2'd2, base + 8'(k), 0, wnack[k], 8'h00);
            xfail += int'(wnack[k]);
          end
          push_item(2'd1, 8'h00, 0, 0, 8'h00);
        end else begin
          if (alen > 0) begin
            if (!rep) push_item(2'd1, 8'h00, 0, 0, 8'h00);
            push_item(2'd0, 8'h00, 0, 0, 8'h00);
          end
          push_item(2'd2, {eff, 1'b1}, 0, 0, 8'h00);
          for (int k = 0; k < len; k++) begin
            push_item(2'd3, 8'h00, (k == len - 1), 0, base ^ 8'(3 * k + 1));
            rd_q.push_back(base ^ 8'(3 * k + 1));
          end
          push_item(2'd1, 8'h00, 0, 0, 8'h00);
        end
      end
    end
    // Issue the request.
    while (!req_ready) @(negedge clk);
    req_op = op; req_chip = chip; req_sub = sub; req_alen = 3'(alen); req_len = 8'(len);
    cfg_rep_start = rep; cfg_fold_en = fold; cfg_fold_mask = mask;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R12", "ready drops after accept", req_ready, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_op = 2'd0; req_chip = 7'h55; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(err == xerr, tag, "err at done", err, xerr);
    chk(fail_cnt == 8'(xfail), tag, "fail count at done", fail_cnt, xfail);
    chk(exp_q.size() == 0, tag, "all script commands issued", exp_q.size(), 0);
    chk(rd_q.size() == 0, "R9", "all read bytes delivered", rd_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R13", "done is one cycle", done, 0);
    chk(err == xerr && fail_cnt == 8'(xfail), "R13", "status held", {err, fail_cnt}, {xerr, 8'(xfail)});
    exp_q.delete(); rd_q.delete(); wr_q.delete();
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(done == 1'b0 && eng_cmd_valid == 1'b0, "R1", "done/cmd quiet after reset", {done, eng_cmd_valid}, 0);
    chk(wr_ready == 1'b0 && rd_valid == 1'b0, "R1", "streams quiet after reset", {wr_ready, rd_valid}, 0);
    // R2 probe acknowledged and refused
    run_txn(2'd0, 7'h50, 0, 0, 0, 0, 0, 0, 0, -1, 0, 8'h00, 0, "R2");
    run_txn(2'd0, 7'h23, 0, 0, 0, 0, 0, 0, 1, -1, 0, 8'h00, 0, "R2");
    // R4 R3 write with two sub-address bytes
    run_txn(2'd1, 7'h51, 32'h0000_A55A, 2, 3, 0, 0, 0, 0, -1, 0, 8'h10, 0, "R4 R3");
    // R5 refused payload bytes are counted, R3 with full length
    run_txn(2'd1, 7'h52, 32'h1234_5678, 4, 4, 0, 0, 0, 0, -1, 32'h5, 8'h40, 0, "R5 R3");
    // R3 zero-length sub-address on write
    run_txn(2'd1, 7'h53, 32'h0000_00FF, 0, 1, 0, 0, 0, 0, -1, 32'h1, 8'h77, 0, "R3 R5");
    // R6 aborts
    run_txn(2'd1, 7'h54, 32'h0000_0102, 2, 2, 0, 0, 0, 1, -1, 0, 8'h00, 0, "R6");
    run_txn(2'd1, 7'h55, 32'h00AB_CDEF, 3, 2, 0, 0, 0, 0, 1, 0, 8'h00, 0, "R6");
    run_txn(2'd2, 7'h56, 32'h0000_0033, 1, 2, 1, 0, 0, 1, -1, 0, 8'h00, 0, "R6");
    // R7 turnarounds
    run_txn(2'd2, 7'h57, 32'h0000_BEEF, 2, 3, 1, 0, 0, 0, -1, 0, 8'hC3, 0, "R7 R9");
    run_txn(2'd2, 7'h58, 32'h0000_0042, 1, 2, 0, 0, 0, 0, -1, 0, 8'h3C, 0, "R7 R9");
    // R8 read without sub-address
    run_txn(2'd2, 7'h59, 0, 0, 4, 0, 0, 0, 0, -1, 0, 8'h81, 0, "R8 R9");
    // R9 single byte read
    run_txn(2'd2, 7'h5A, 32'h0000_0007, 1, 1, 1, 0, 0, 0, -1, 0, 8'hE0, 0, "R9");
    // R10 fold of high sub-address bits
    run_txn(2'd1, 7'h50, 32'h0000_0312, 1, 1, 0, 1, 7'h07, 0, -1, 0, 8'h21, 0, "R10");
    run_txn(2'd2, 7'h40, 32'h0000_0005, 0, 2, 0, 1, 7'h03, 0, -1, 0, 8'h66, 0, "R10");
    // R12 request while busy is ignored
    run_txn(2'd1, 7'h5B, 32'h0000_9988, 2, 3, 0, 0, 0, 0, -1, 0, 8'h90, 1, "R12");
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule